// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes a three-wire serial stream (bit clock, data and a load strobe) and turns it into four sets of configuration fields. Each serial bit clock rising edge pushes one data bit into a 24-bit word register. The first bit sent lands at the top of the word. When the load strobe rises, the whole word is written into exactly one of four holding latches.

The latch is picked by the two bits shifted in last, which are the word's least significant bits. Two of the latches hold a 14-bit reference-divider ratio. The other two hold a divider pair made of a 6-bit A count and a 12-bit B count. The serial pins are treated as asynchronous. They are brought into the system clock domain, and their edges are found there, so the serial clock must run well below the system clock.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset every output field (both reference ratios and both A/B pairs) reads zero.
- R2: Each rising edge of the serial bit clock shifts exactly one data bit into the word, most significant bit first. Holding the bit clock high for many system cycles still shifts only one bit.
- R3: A transfer happens only on a rising edge of the load strobe. Holding the strobe high, shifting while it is high, or letting it fall leaves every output unchanged.
- R4: Select code 2'b00 in word bits 1:0 writes word bits 15:2 into reference ratio 0.
- R5: Select code 2'b01 writes word bits 7:2 into A count 0 and word bits 19:8 into B count 0.
- R6: Select code 2'b10 writes word bits 15:2 into reference ratio 1.
- R7: Select code 2'b11 writes word bits 7:2 into A count 1 and word bits 19:8 into B count 1.
- R8: A load leaves every latch it does not address at its previous value.
- R9: Word bits outside the addressed latch's fields have no effect on any output. These are bits 23:16 for a reference word and bits 23:20 for an A/B word.
- R10: When more than 24 bits are shifted before a load, only the last 24 bits decide the latch and its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on ser_clk rising edges |
| ser_load | input | 1 | Load strobe; its rising edge writes one latch |
| ref_div_0 | output | 14 | Reference ratio, latch select 00 |
| acnt_0 | output | 6 | A count, latch select 01 |
| bcnt_0 | output | 12 | B count, latch select 01 |
| ref_div_1 | output | 14 | Reference ratio, latch select 10 |
| acnt_1 | output | 6 | A count, latch select 11 |
| bcnt_1 | output | 12 | B count, latch select 11 |

## Verification
The assertions take for granted that the serial data is stable for at least the synchroniser depth around each bit clock rising edge. They also take for granted that the bit clock stays idle while the load strobe rises, so the word does not change between the edge being found and the transfer. The stimulus holds each bit clock level for several system cycles and changes data only while the bit clock is low. It raises and lowers the load strobe only after the last bit has settled through the synchroniser.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int SEL_W     = 2;
   localparam int NUM_SLOTS = 4;
   localparam int NUM_PAIRS = NUM_SLOTS / 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_REF_LO = 2'b00,
      SEL_AB_LO  = 2'b01,
      SEL_REF_HI = 2'b10,
      SEL_AB_HI  = 2'b11
   } latch_sel_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/shift_word.sv
module shift_word #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_o <= '0;
      else if (shift_en) word_o <= {word_o[WORD_W-2:0], bit_i};
   end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
   import cfg_loader_pkg::*;
#(
   parameter int WORD_W  = 24,
   parameter int REF_W   = 14,
   parameter int REF_LSB = 2,
   parameter int A_W     = 6,
   parameter int A_LSB   = 2,
   parameter int B_W     = 12,
   parameter int B_LSB   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_en,
   input  logic [WORD_W-1:0]         word_i,
   output logic [NUM_PAIRS*REF_W-1:0] ref_o,
   output logic [NUM_PAIRS*A_W-1:0]   a_o,
   output logic [NUM_PAIRS*B_W-1:0]   b_o
);
   latch_sel_e sel;
   logic       unused_hi_bits;

   assign sel            = latch_sel_e'(word_i[SEL_W-1:0]);
   assign unused_hi_bits = ^word_i[WORD_W-1:B_LSB+B_W];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam latch_sel_e MY_SEL = latch_sel_e'(SEL_W'(s));
      localparam int         PAIR   = s / 2;
      logic hit;
      assign hit = load_en && (sel == MY_SEL);

      if (MY_SEL == SEL_REF_LO || MY_SEL == SEL_REF_HI) begin : g_ref
         logic [REF_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= word_i[REF_LSB +: REF_W];
         end
         assign ref_o[PAIR*REF_W +: REF_W] = q;
      end else begin : g_ab
         logic [A_W-1:0] a_q;
         logic [B_W-1:0] b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_q <= '0;
               b_q <= '0;
            end else if (hit) begin
               a_q <= word_i[A_LSB +: A_W];
               b_q <= word_i[B_LSB +: B_W];
            end
         end
         assign a_o[PAIR*A_W +: A_W] = a_q;
         assign b_o[PAIR*B_W +: B_W] = b_q;
      end
   end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
   parameter int WORD_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter int REF_W       = 14,
   parameter int REF_LSB     = 2,
   parameter int A_W         = 6,
   parameter int A_LSB       = 2,
   parameter int B_W         = 12,
   parameter int B_LSB       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_dat,
   input  logic             ser_load,
   output logic [REF_W-1:0] ref_div_0,
   output logic [A_W-1:0]   acnt_0,
   output logic [B_W-1:0]   bcnt_0,
   output logic [REF_W-1:0] ref_div_1,
   output logic [A_W-1:0]   acnt_1,
   output logic [B_W-1:0]   bcnt_1
);
   localparam int SEL_W = cfg_loader_pkg::SEL_W;
   localparam int PAIRS = cfg_loader_pkg::NUM_PAIRS;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (REF_LSB < SEL_W || REF_LSB + REF_W > WORD_W) begin : g_chk_ref
      $error("reference field must sit above the select bits and inside the word");
   end
   if (A_LSB < SEL_W || A_LSB + A_W > B_LSB) begin : g_chk_a
      $error("A field must sit above the select bits and below the B field");
   end
   if (B_LSB + B_W >= WORD_W) begin : g_chk_b
      $error("B field must leave at least one spare bit at the top of the word");
   end

   logic                    sclk_level, sclk_rise;
   logic                    load_level, load_rise;
   logic [SYNC_STAGES-1:0]  dat_chain_q;
   logic                    sdat_s;
   logic [WORD_W-1:0]       word_q;
   logic [PAIRS*REF_W-1:0]  ref_flat;
   logic [PAIRS*A_W-1:0]    a_flat;
   logic [PAIRS*B_W-1:0]    b_flat;
   logic                    unused_levels;

   edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ser_clk),
      .level_o(sclk_level), .rise_o(sclk_rise)
   );

   edge_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ser_load),
      .level_o(load_level), .rise_o(load_rise)
   );

   assign unused_levels = sclk_level ^ load_level;

   // data chain has the same depth as the bit clock chain so the two stay aligned
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dat_chain_q <= '0;
      else        dat_chain_q <= {dat_chain_q[SYNC_STAGES-2:0], ser_dat};
   end
   assign sdat_s = dat_chain_q[SYNC_STAGES-1];

   shift_word #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
      .bit_i(sdat_s), .word_o(word_q)
   );

   cfg_latch_bank #(
      .WORD_W(WORD_W), .REF_W(REF_W), .REF_LSB(REF_LSB),
      .A_W(A_W), .A_LSB(A_LSB), .B_W(B_W), .B_LSB(B_LSB)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .load_en(load_rise), .word_i(word_q),
      .ref_o(ref_flat), .a_o(a_flat), .b_o(b_flat)
   );

   assign ref_div_0 = ref_flat[0 +: REF_W];
   assign ref_div_1 = ref_flat[REF_W +: REF_W];
   assign acnt_0    = a_flat[0 +: A_W];
   assign acnt_1    = a_flat[A_W +: A_W];
   assign bcnt_0    = b_flat[0 +: B_W];
   assign bcnt_1    = b_flat[B_W +: B_W];
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
   parameter int WORD_W  = 24,
   parameter int REF_W   = 14,
   parameter int REF_LSB = 2,
   parameter int A_W     = 6,
   parameter int A_LSB   = 2,
   parameter int B_W     = 12,
   parameter int B_LSB   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk_rise,
   input logic              sdat_s,
   input logic              load_rise,
   input logic [WORD_W-1:0] word,
   input logic [REF_W-1:0]  ref0,
   input logic [A_W-1:0]    a0,
   input logic [B_W-1:0]    b0,
   input logic [REF_W-1:0]  ref1,
   input logic [A_W-1:0]    a1,
   input logic [B_W-1:0]    b1
);
   a_r2_one_bit_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> word == {$past(word[WORD_W-2:0]), $past(sdat_s)});

   a_r2_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(word));

   a_r3_no_load_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !load_rise |=> $stable(ref0) && $stable(a0) && $stable(b0)
                     && $stable(ref1) && $stable(a1) && $stable(b1));

   a_r4_ref0_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] == 2'b00 |=> ref0 == $past(word[REF_LSB +: REF_W]));

   a_r5_ab0_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] == 2'b01 |=>
         a0 == $past(word[A_LSB +: A_W]) && b0 == $past(word[B_LSB +: B_W]));

   a_r6_ref1_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] == 2'b10 |=> ref1 == $past(word[REF_LSB +: REF_W]));

   a_r7_ab1_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] == 2'b11 |=>
         a1 == $past(word[A_LSB +: A_W]) && b1 == $past(word[B_LSB +: B_W]));

   a_r8_ref0_kept: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] != 2'b00 |=> $stable(ref0));

   a_r8_ab0_kept: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] != 2'b01 |=> $stable(a0) && $stable(b0));

   a_r8_ref1_kept: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] != 2'b10 |=> $stable(ref1));

   a_r8_ab1_kept: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise && word[1:0] != 2'b11 |=> $stable(a1) && $stable(b1));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
   .WORD_W(WORD_W), .REF_W(REF_W), .REF_LSB(REF_LSB),
   .A_W(A_W), .A_LSB(A_LSB), .B_W(B_W), .B_LSB(B_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sdat_s(sdat_s),
   .load_rise(load_rise), .word(word_q),
   .ref0(ref_div_0), .a0(acnt_0), .b0(bcnt_0),
   .ref1(ref_div_1), .a1(acnt_1), .b1(bcnt_1)
);

// File: tb/serial_cfg_loader_test.sv
`timescale 1ns/1ps
module serial_cfg_loader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_load = 1'b0;
   logic [13:0] ref_div_0, ref_div_1;
   logic [5:0]  acnt_0, acnt_1;
   logic [11:0] bcnt_0, bcnt_1;

   int n_checks = 0;
   int n_fails  = 0;

   logic [13:0] e_ref0 = '0, e_ref1 = '0;
   logic [5:0]  e_a0 = '0, e_a1 = '0;
   logic [11:0] e_b0 = '0, e_b1 = '0;

   always #2.5 clk = ~clk;

   serial_cfg_loader uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_load(ser_load), .ref_div_0(ref_div_0), .acnt_0(acnt_0),
      .bcnt_0(bcnt_0), .ref_div_1(ref_div_1), .acnt_1(acnt_1), .bcnt_1(bcnt_1)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " ref_div_0"}, 32'(ref_div_0), 32'(e_ref0));
      chk({tag, " acnt_0"},    32'(acnt_0),    32'(e_a0));
      chk({tag, " bcnt_0"},    32'(bcnt_0),    32'(e_b0));
      chk({tag, " ref_div_1"}, 32'(ref_div_1), 32'(e_ref1));
      chk({tag, " acnt_1"},    32'(acnt_1),    32'(e_a1));
      chk({tag, " bcnt_1"},    32'(bcnt_1),    32'(e_b1));
   endtask

   // sends the low n bits of bits, highest first; data changes only while ser_clk is low
   task automatic send_bits(input logic [63:0] bits, input int n, input int hi_clks);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk) ser_dat = bits[i];
         repeat (4) @(negedge clk);
         ser_clk = 1'b1;
         repeat (hi_clks) @(negedge clk);
         ser_clk = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic pulse_load();
      repeat (4) @(negedge clk);
      ser_load = 1'b1;
      repeat (6) @(negedge clk);
      ser_load = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   function automatic logic [23:0] ref_word(input logic [7:0] junk, input logic [13:0] v,
                                            input logic [1:0] sel);
      return {junk, v, sel};
   endfunction

   function automatic logic [23:0] ab_word(input logic [3:0] junk, input logic [11:0] b,
                                           input logic [5:0] a, input logic [1:0] sel);
      return {junk, b, a, sel};
   endfunction

   task automatic t_reset();
      check_all("R1 reset");
   endtask

   task automatic t_ref0();
      send_bits(64'(ref_word(8'hFF, 14'h2A5C, 2'b00)), 24, 4);
      pulse_load();
      e_ref0 = 14'h2A5C;
      check_all("R4 R8 R9 ref0 write");
   endtask

   task automatic t_ab0();
      send_bits(64'(ab_word(4'hA, 12'hC3E, 6'h2B, 2'b01)), 24, 4);
      pulse_load();
      e_a0 = 6'h2B; e_b0 = 12'hC3E;
      check_all("R5 R8 R9 ab0 write");
   endtask

   task automatic t_ref1_long_high();
      send_bits(64'(ref_word(8'h5A, 14'h1357, 2'b10)), 24, 12);
      pulse_load();
      e_ref1 = 14'h1357;
      check_all("R6 R2 ref1 write long bit clock high");
   endtask

   task automatic t_ab1();
      send_bits(64'(ab_word(4'hF, 12'h0F1, 6'h3F, 2'b11)), 24, 3);
      pulse_load();
      e_a1 = 6'h3F; e_b1 = 12'h0F1;
      check_all("R7 R8 ab1 write");
   endtask

   task automatic t_overlong();
      send_bits({36'h0, 4'h9, ref_word(8'h00, 14'h0001, 2'b00)}, 28, 4);
      pulse_load();
      e_ref0 = 14'h0001;
      check_all("R10 R2 28 bits shifted");
   endtask

   task automatic t_load_level();
      repeat (4) @(negedge clk);
      ser_load = 1'b1;
      repeat (10) @(negedge clk);
      check_all("R3 first rise with old word");
      send_bits(64'(ref_word(8'h33, 14'h3FFF, 2'b10)), 24, 4);
      repeat (8) @(negedge clk);
      check_all("R3 shift while load held");
      ser_load = 1'b0;
      repeat (10) @(negedge clk);
      check_all("R3 load fall");
      pulse_load();
      e_ref1 = 14'h3FFF;
      check_all("R3 R6 next rise writes");
   endtask

   task automatic t_all_zero_fields();
      send_bits(64'(ab_word(4'hF, 12'h000, 6'h00, 2'b01)), 24, 4);
      pulse_load();
      e_a0 = '0; e_b0 = '0;
      check_all("R5 R9 ab0 cleared with junk top");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_ref0();
      t_ab0();
      t_ref1_long_high();
      t_ab1();
      t_overlong();
      t_load_level();
      t_all_zero_fields();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule